// File: doc/BRIEF.md
# Platform interrupt controller core

This block collects interrupt requests from a set of peripheral sources and routes them to a small number of target contexts, usually processor harts in their privilege modes. Each source has a programmable priority. Each context has its own enable mask and priority threshold. A per-source mode input selects whether the line is taken as a level or as a rising edge. A gateway stage turns each line into a pending bit and holds back any further request from that source while it is being serviced.

Software talks to the block through a plain 32-bit word register port. Every access is a single request cycle, and read data comes back on the following cycle. A context services an interrupt in two steps. It reads its claim register to learn the winning source ID, and that read also takes the source off the pending set. When the handler has finished, the context writes the same ID back to the same register. A level source whose line is still high then becomes pending again straight away. An edge source waits for its next rising edge.

Top module: `intc_core`

## Requirements
- R1: After reset every priority, pending, enable, threshold and claim register reads 0 and every `irq_o` bit is low.
- R2: Byte addresses are 0x0 + 4*s for the priority of source s, 0x1000 + 4*w for pending word w, 0x2000 + 0x80*c + 4*w for the enable word w of context c, 0x200000 + 0x1000*c for the threshold of context c, and that address + 4 for its claim register. Bit s%32 of a word belongs to source s. Priority and threshold are 5 bits wide and their upper bits read 0. Unmapped or misaligned addresses read 0, and writes to them change nothing.
- R3: Source 0 never becomes pending. Its priority and enable bits stay 0 whatever is written to them.
- R4: When `edge_mode_i[s]`=0 a high input sets pending. When it is 1, a rising edge sets pending. Pending does not depend on any enable.
- R5: A low `irq_o[c]` rises only while some source that is pending and enabled for c has a priority strictly greater than the threshold of c.
- R6: A claim read returns the pending source enabled for that context with the highest priority, taking the lower ID on a tie, and clears its pending bit. It returns 0 when nothing is eligible.
- R7: Claims are granted to eligible sources at or below the threshold too. Once high, `irq_o[c]` stays high as long as any source pending and enabled for c remains, and drops when none is left.
- R8: A source held by one context cannot be handed to another. A claim read from another context returns 0, and that context's `irq_o` drops once nothing else is eligible for it.
- R9: A level-mode pending bit stays set after the input falls. A completion leaves pending set again if the input is still high.
- R10: A claimed source cannot become pending again until it is completed. An edge during that time is lost, and an edge-mode source stays clear after completion until a new rising edge.
- R11: A completion write carrying an ID that the writing context does not hold is ignored.
- R12: Read data appears on `rdata_o` in the cycle after the request and is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt request line per source |
| edge_mode_i | input | NUM_SRC | Per-source trigger mode, 1 selects rising edge |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read request |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
A claim read and a gateway update on the same source can happen in the same clock cycle. So can a completion write and a level line that is still asserted, which re-arms the source on the next cycle. The bench provokes the first case by pulsing an edge source while its claim is outstanding, and the second by completing level sources with their input held high. Each result is judged against a bench model that clears pending on claim, blocks in-flight sources and re-pends level sources on completion. The randomized phase interleaves line toggles, claims, completions and reconfiguration so that these collisions also arise in mixed order.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PRIO, SEL_PEND, SEL_EN, SEL_THR, SEL_CLAIM
  } sel_e;

  typedef struct packed {
    sel_e        sel;
    logic [15:0] idx;
    logic [7:0]  ctx;
  } dec_t;
endpackage

// File: rtl/intc_decode.sv
`timescale 1ns/1ps
module intc_decode import intc_pkg::*; #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_CTX   = 3,
  parameter int unsigned NUM_WORDS = 1,
  parameter int unsigned ADDR_W    = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam logic [31:0] PRIO_END = 32'(NUM_SRC * 4);
  localparam logic [31:0] WORD_SPAN = 32'(NUM_WORDS * 4);

  logic [31:0] a;
  assign a = 32'(addr_i);

  always_comb begin
    dec_o     = '0;
    dec_o.sel = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (a < PRIO_END) begin
        dec_o.sel = SEL_PRIO;
        dec_o.idx = 16'(a >> 2);
      end else if (a >= PEND_BASE && a < PEND_BASE + WORD_SPAN) begin
        dec_o.sel = SEL_PEND;
        dec_o.idx = 16'((a - PEND_BASE) >> 2);
      end
      for (int c = 0; c < NUM_CTX; c++) begin
        if (a >= EN_BASE + 32'(c) * EN_STRIDE &&
            a <  EN_BASE + 32'(c) * EN_STRIDE + WORD_SPAN) begin
          dec_o.sel = SEL_EN;
          dec_o.ctx = 8'(c);
          dec_o.idx = 16'((a - EN_BASE - 32'(c) * EN_STRIDE) >> 2);
        end
        if (a == CTX_BASE + 32'(c) * CTX_STRIDE) begin
          dec_o.sel = SEL_THR;
          dec_o.ctx = 8'(c);
        end
        if (a == CTX_BASE + 32'(c) * CTX_STRIDE + 32'd4) begin
          dec_o.sel = SEL_CLAIM;
          dec_o.ctx = 8'(c);
        end
      end
    end
  end
endmodule

// File: rtl/intc_gateway.sv
`timescale 1ns/1ps
module intc_gateway #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] edge_mode_i,
  input  logic [NUM_SRC-1:0] inflight_i,
  input  logic [NUM_SRC-1:0] claim_clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  assign pend_o[0] = 1'b0;  // ID 0 reserved

  for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
    logic src_q, pend_q, trig;
    assign trig = edge_mode_i[s] ? (src_i[s] & ~src_q) : src_i[s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        src_q  <= src_i[s];
        // claim wins over a same-cycle request; in-flight blocks re-arm
        if (pend_q) pend_q <= ~claim_clr_i[s];
        else        pend_q <= trig & ~inflight_i[s] & ~claim_clr_i[s];
      end
    end
    assign pend_o[s] = pend_q;
  end
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 5,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             elig_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [ID_W-1:0]                best_id_o,
  output logic                           any_elig_o,
  output logic                           any_above_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_id_o   = '0;
    best_p      = '0;
    any_elig_o  = 1'b0;
    any_above_o = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (elig_i[s]) begin
        // strict compare keeps the lower ID on a tie
        if (!any_elig_o || prio_i[s] > best_p) begin
          best_id_o = ID_W'(s);
          best_p    = prio_i[s];
        end
        any_elig_o = 1'b1;
        if (prio_i[s] > thr_i) any_above_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_core.sv
`timescale 1ns/1ps
module intc_core import intc_pkg::*; #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 3,
  parameter int unsigned PRIO_W  = 5,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] edge_mode_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);
  localparam int unsigned ID_W      = $clog2(NUM_SRC);
  localparam int unsigned NUM_WORDS = (NUM_SRC + DATA_W - 1) / DATA_W;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q, claimed_q, claim_m, done_m;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_CTX-1:0][ID_W-1:0]   best_id;
  logic [NUM_CTX-1:0]             any_elig, any_above, irq_q;
  logic [NUM_SRC-1:0]             pend_q, inflight, claim_clr;
  logic [DATA_W-1:0]              rdata_q, rd_val;
  dec_t                           dec;
  logic                           rd, wr;

  assign rd = req_i & ~we_i;
  assign wr = req_i & we_i;

  intc_decode #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr_i(addr_i), .dec_o(dec)
  );

  intc_gateway #(.NUM_SRC(NUM_SRC)) u_gw (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .edge_mode_i(edge_mode_i),
    .inflight_i(inflight), .claim_clr_i(claim_clr), .pend_o(pend_q)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .elig_i(pend_q & en_q[c]), .prio_i(prio_q), .thr_i(thr_q[c]),
      .best_id_o(best_id[c]), .any_elig_o(any_elig[c]), .any_above_o(any_above[c])
    );
  end

  // claim and completion masks
  always_comb begin
    claim_m   = '0;
    done_m    = '0;
    claim_clr = '0;
    inflight  = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (rd && dec.sel == SEL_CLAIM && dec.ctx == 8'(c) && any_elig[c] &&
            best_id[c] == ID_W'(s))
          claim_m[c][s] = 1'b1;
        if (wr && dec.sel == SEL_CLAIM && dec.ctx == 8'(c) &&
            wdata_i == DATA_W'(s) && claimed_q[c][s])
          done_m[c][s] = 1'b1;
        claim_clr[s] = claim_clr[s] | claim_m[c][s];
        inflight[s]  = inflight[s] | claimed_q[c][s];
      end
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    unique case (dec.sel)
      SEL_PRIO:
        for (int s = 0; s < NUM_SRC; s++)
          if (dec.idx == 16'(s)) rd_val = DATA_W'(prio_q[s]);
      SEL_PEND:
        for (int s = 0; s < NUM_SRC; s++)
          if (dec.idx == 16'(s / DATA_W)) rd_val[s % DATA_W] = pend_q[s];
      SEL_EN:
        for (int c = 0; c < NUM_CTX; c++)
          for (int s = 0; s < NUM_SRC; s++)
            if (dec.ctx == 8'(c) && dec.idx == 16'(s / DATA_W))
              rd_val[s % DATA_W] = en_q[c][s];
      SEL_THR:
        for (int c = 0; c < NUM_CTX; c++)
          if (dec.ctx == 8'(c)) rd_val = DATA_W'(thr_q[c]);
      SEL_CLAIM:
        for (int c = 0; c < NUM_CTX; c++)
          if (dec.ctx == 8'(c) && any_elig[c]) rd_val = DATA_W'(best_id[c]);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q    <= '0;
      en_q      <= '0;
      thr_q     <= '0;
      claimed_q <= '0;
      irq_q     <= '0;
      rdata_q   <= '0;
    end else begin
      rdata_q   <= rd ? rd_val : '0;
      claimed_q <= (claimed_q & ~done_m) | claim_m;
      for (int c = 0; c < NUM_CTX; c++) begin
        // raise above threshold, hold while anything eligible remains
        irq_q[c] <= any_elig[c] & (any_above[c] | irq_q[c]);
      end
      if (wr) begin
        for (int s = 1; s < NUM_SRC; s++)
          if (dec.sel == SEL_PRIO && dec.idx == 16'(s))
            prio_q[s] <= wdata_i[PRIO_W-1:0];
        for (int c = 0; c < NUM_CTX; c++) begin
          if (dec.sel == SEL_THR && dec.ctx == 8'(c))
            thr_q[c] <= wdata_i[PRIO_W-1:0];
          for (int s = 1; s < NUM_SRC; s++)
            if (dec.sel == SEL_EN && dec.ctx == 8'(c) && dec.idx == 16'(s / DATA_W))
              en_q[c][s] <= wdata_i[s % DATA_W];
        end
      end
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/intc_core_chk.sv
`timescale 1ns/1ps
module intc_core_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 3,
  parameter int unsigned DATA_W  = 32
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            req_i,
  input logic                            we_i,
  input logic [DATA_W-1:0]               rdata_o,
  input logic [NUM_CTX-1:0]              irq_o,
  input logic [NUM_SRC-1:0]              pend_q,
  input logic [NUM_SRC-1:0]              inflight,
  input logic [NUM_CTX-1:0]              any_elig,
  input logic [NUM_CTX-1:0]              any_above,
  input logic [NUM_CTX-1:0][NUM_SRC-1:0] claimed_q
);
  assert_rdata_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> rdata_o == '0);

  assert_src0_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q[0]);

  assert_no_pend_inflight_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & inflight) == '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [NUM_CTX-1:0] owners;
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_col
      assign owners[c] = claimed_q[c][s];
    end
    assert_single_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owners));
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    assert_irq_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[c]) |-> $past(any_above[c]));
    assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> $past(any_elig[c]));
  end
endmodule

bind intc_core intc_core_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/intc_core_test.sv
`timescale 1ns/1ps
module intc_core_test;
  localparam int NS = 32;
  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [NS-1:0] mode = 32'h0000_FFFE;  // 1..15 edge, 16..31 level
  logic          req = 1'b0, we = 1'b0;
  logic [23:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit [31:0] m_pend, m_src;
  bit [4:0]  m_prio[NS];
  bit [31:0] m_en[NC];
  bit [4:0]  m_thr[NC];
  bit [31:0] m_cl[NC];
  bit [NC-1:0] m_irq;

  intc_core uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .edge_mode_i(mode),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [23:0] a_prio(int s); return 24'(s * 4); endfunction
  function automatic logic [23:0] a_en(int c); return 24'(32'h2000 + c * 32'h80); endfunction
  function automatic logic [23:0] a_thr(int c); return 24'(32'h200000 + c * 32'h1000); endfunction
  function automatic logic [23:0] a_clm(int c); return 24'(32'h200004 + c * 32'h1000); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_best(int c);
    int id = 0;
    bit f = 0;
    for (int s = 0; s < NS; s++)
      if (m_pend[s] && m_en[c][s] && (!f || m_prio[s] > m_prio[id])) begin
        id = s; f = 1;
      end
    return id;
  endfunction

  function automatic void m_upd_irq();
    for (int c = 0; c < NC; c++) begin
      bit any = 0, above = 0;
      for (int s = 0; s < NS; s++)
        if (m_pend[s] && m_en[c][s]) begin
          any = 1;
          if (m_prio[s] > m_thr[c]) above = 1;
        end
      m_irq[c] = any && (above || m_irq[c]);
    end
  endfunction

  function automatic bit m_infl(int s);
    bit r = 0;
    for (int c = 0; c < NC; c++) r |= m_cl[c][s];
    return r;
  endfunction

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [23:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; req = 0;
  endtask

  task automatic chk_irq(string tag);
    settle();
    m_upd_irq();
    check(tag, 32'(irq), 32'(m_irq));
  endtask

  task automatic chk_pend(string tag);
    logic [31:0] d;
    rd(24'h1000, d);
    check(tag, d, m_pend);
  endtask

  task automatic drv(int s, bit v);
    bit old = m_src[s];
    m_src[s] = v;
    src[s] = v;
    if (s != 0 && !m_infl(s) && (mode[s] ? (v && !old) : v)) m_pend[s] = 1;
    settle();
    m_upd_irq();
  endtask

  task automatic claim(int c, string tag);
    logic [31:0] d;
    int e = m_best(c);
    rd(a_clm(c), d);
    check(tag, d, 32'(e));
    if (e != 0) begin m_pend[e] = 0; m_cl[c][e] = 1; end
    settle();
    m_upd_irq();
  endtask

  task automatic complete(int c, int id);
    wr(a_clm(c), 32'(id));
    if (id >= 0 && id < NS && m_cl[c][id]) begin
      m_cl[c][id] = 0;
      if (!mode[id] && m_src[id]) m_pend[id] = 1;
    end
    settle();
    m_upd_irq();
  endtask

  task automatic set_prio(int s, logic [31:0] v);
    wr(a_prio(s), v);
    if (s != 0) m_prio[s] = v[4:0];
  endtask

  task automatic set_en(int c, logic [31:0] v);
    wr(a_en(c), v);
    m_en[c] = v & 32'hFFFF_FFFE;
  endtask

  task automatic set_thr(int c, logic [31:0] v);
    wr(a_thr(c), v);
    m_thr[c] = v[4:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd(a_prio(5), d);  check("R1 prio", d, 0);
    rd(24'h1000, d);   check("R1 pend", d, 0);
    rd(a_en(0), d);    check("R1 en", d, 0);
    rd(a_thr(1), d);   check("R1 thr", d, 0);
    rd(a_clm(2), d);   check("R1 claim", d, 0);
    @(negedge clk);    check("R12 idle rdata", rdata, 0);

    // R2 / R3 register layout and masking
    set_prio(7, 32'hFFFF_FFE7); rd(a_prio(7), d); check("R2 prio mask", d, 32'h7);
    set_thr(2, 32'h3F);         rd(a_thr(2), d);  check("R2 thr mask", d, 32'h1F);
    set_en(1, 32'hFFFF_FFFF);   rd(a_en(1), d);   check("R3 en bit0", d, 32'hFFFF_FFFE);
    set_prio(0, 32'h5);         rd(a_prio(0), d); check("R3 prio0", d, 0);
    wr(24'h00001D, 32'h1);      rd(a_prio(7), d); check("R2 misaligned", d, 32'h7);
    wr(24'h200008, 32'h9);      rd(a_thr(0), d);  check("R2 unmapped wr", d, 0);
    rd(24'h003000, d);          check("R2 unmapped rd", d, 0);
    drv(0, 1); chk_pend("R3 src0 pend"); drv(0, 0);

    // configuration
    for (int s = 1; s < NS; s++) set_prio(s, 32'(s));
    set_thr(0, 8); set_thr(1, 16); set_thr(2, 24);
    set_en(0, 32'h4000_07FE); set_en(1, 32'h401F_F800); set_en(2, 32'hFFF8_0000);

    // R5 threshold: edge sources 5..10 in context 0
    for (int i = 5; i <= 10; i++) begin
      drv(i, 1);
      check("R5 irq vs thr", 32'(irq[0]), 32'(i > 8));
      chk_pend("R4 edge pend");
    end
    // R7 claim order below threshold, line held
    for (int i = 10; i >= 5; i--) begin
      claim(0, "R7 claim order");
      complete(0, i);
      check("R7 irq hold", 32'(irq[0]), 32'(i != 5));
    end
    for (int i = 5; i <= 10; i++) drv(i, 0);

    // R8 shared source 30
    drv(30, 1);
    check("R8 irq all", 32'(irq), 32'h7);
    claim(0, "R8 first claim");
    claim(1, "R8 second claim");
    claim(2, "R8 third claim");
    check("R8 irq drop", 32'(irq), 0);
    drv(30, 0);
    complete(0, 30);
    chk_pend("R8 pend after");

    // R9 / R11 level source 20, context 1
    drv(20, 1); drv(20, 0);
    chk_pend("R9 latched");
    drv(20, 1);
    claim(1, "R9 claim");
    chk_pend("R6 claim clears");
    complete(1, 20);
    chk_pend("R9 re-pend");
    claim(1, "R9 reclaim");
    complete(1, 19);
    complete(0, 20);
    chk_pend("R11 ignored");
    claim(1, "R11 empty claim");
    drv(20, 0);
    complete(1, 20);
    chk_pend("R9 level low");

    // R6 tie, R10 edge in flight
    set_prio(4, 3);
    drv(3, 1); drv(4, 1);
    claim(0, "R6 tie lower id");
    drv(3, 0); drv(3, 1);
    chk_pend("R10 edge blocked");
    complete(0, 3);
    chk_pend("R10 stays clear");
    claim(0, "R6 next");
    complete(0, 4);
    drv(3, 0); drv(3, 1);
    chk_pend("R10 new edge");
    claim(0, "R6 edge claim");
    complete(0, 3);
    drv(3, 0); drv(4, 0);
    claim(0, "R6 none");

    // randomized mix
    for (int k = 0; k < 400; k++) begin
      int op = $urandom % 8;
      int c = $urandom % NC;
      case (op)
        0, 1: drv($urandom % NS, 1'($urandom));
        2: claim(c, "R6 rnd claim");
        3: begin
          int id = $urandom % 40;
          if ($urandom % 2)
            for (int s = 0; s < NS; s++) if (m_cl[c][s]) id = s;
          complete(c, id);
        end
        4: chk_pend("R4 rnd pend");
        5: set_prio($urandom % NS, $urandom);
        6: set_en(c, $urandom);
        default: set_thr(c, $urandom);
      endcase
      chk_irq("R7 rnd irq");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule